// File: doc/BRIEF.md
# Address-Match Debug Trigger Bank

This block holds a small set of debug triggers. Each trigger compares one address with the program counter of the instruction that is about to retire, with the data address of a store that is about to be performed, or with both. When an enabled trigger matches, the block raises a trap request in the same cycle, so the core can act before the operation takes effect. The request comes with the index of the trigger that fired.

Software sets up the triggers through a small register port. A select register picks a trigger, and the control and match registers then act on that trigger. The only match kind is an exact address compare, so the type field of every control register reads back as the address-match code whatever was written.

When a trigger fires, the block also handles the machine interrupt enable as a trap does. The current enable is saved into a saved-enable bit and into the firing trigger's control register, and the enable is then cleared. A return strobe restores the enable from the saved bit.

Top module: `addr_trigger_bank`

## Requirements
- R1: Bits [31:28] of a control register read back as 4'h2 (address match) whatever value was written to them.
- R2: A trigger with its execute enable set (control bit 1) makes `trig_fire` high in the same cycle that `retire_valid` is high and `retire_pc` equals its match address, with `trig_idx` giving its index.
- R3: A trigger with its store enable set (control bit 0) makes `trig_fire` high in the same cycle that `store_valid` is high and `store_addr` equals its match address.
- R4: A trigger never fires for a condition whose enable bit is clear. A trigger with both enable bits clear never fires, whatever its match address.
- R5: When several triggers match in one cycle, `trig_idx` gives the lowest index among them.
- R6: On the clock edge that ends a firing cycle, `ie_saved` takes the old value of `ie`, bit 2 of the firing trigger's control register takes the same value, and `ie` becomes 0.
- R7: A `trap_ret` strobe sets `ie` to `ie_saved` on the next edge. A firing in the same cycle takes priority over the strobe.
- R8: Register address 0 is the select register. It reads back the selected index, and addresses 1 (control) and 2 (match) read and write the selected trigger. Address 3 reads 0.
- R9: After reset, `ie`, `ie_saved`, the select register, all enable bits and all match addresses are 0. No trigger fires.
- R10: An `ie_wr` strobe sets `ie` to `ie_wdata` on the next edge, but only when no firing and no return happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_valid | input | 1 | An instruction is about to retire |
| retire_pc | input | AW | Address of that instruction |
| store_valid | input | 1 | A store is about to be performed |
| store_addr | input | AW | Data address of that store |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 select, 1 control, 2 match |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| trap_ret | input | 1 | Return from trap: restore the interrupt enable |
| ie_wr | input | 1 | Software write of the interrupt enable |
| ie_wdata | input | 1 | Value for that write |
| trig_fire | output | 1 | A trigger matched in this cycle |
| trig_idx | output | IW | Index of the firing trigger (0 when none fires) |
| ie | output | 1 | Current machine interrupt enable |
| ie_saved | output | 1 | Interrupt enable saved at the last firing |

## Verification
The assertions check the interrupt-enable hand-off on every cycle: clear after a firing, save of the old value, restore on return, and no firing without a valid retire or store. They also check that the type field always reads as address match and that the reported index is in range. Only the bench scenarios can show that the right trigger is chosen. That covers the separate execute and store enables, lowest-index priority when several triggers match, selection through the select register, and the saved bit that ends up in the firing trigger's control register.

// File: rtl/dbgtrig_pkg.sv
// Shared constants and types for the address-match trigger bank.
// Assumes a 32-bit register data path.
package dbgtrig_pkg;
    localparam int          REG_DW       = 32;
    localparam logic [3:0]  TYPE_ADDRESS = 4'h2;
    localparam int          CB_STORE     = 0;
    localparam int          CB_EXEC      = 1;
    localparam int          CB_PREV_IE   = 2;

    typedef enum logic [1:0] {
        CFG_SELECT = 2'd0,
        CFG_CTRL   = 2'd1,
        CFG_MATCH  = 2'd2,
        CFG_RSVD   = 2'd3
    } cfg_reg_e;
endpackage

// File: rtl/dbgtrig_slot.sv
// One trigger: its enable bits, its saved-enable bit and its match address,
// plus the compare against the retiring PC and the store address.
// Assumes the writes arrive already decoded for this slot.
module dbgtrig_slot
    import dbgtrig_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [2:0]        ctrl_wbits,
    input  logic              match_we,
    input  logic [AW-1:0]     match_wdata,
    input  logic              fired_here,
    input  logic              ie_now,
    input  logic              retire_valid,
    input  logic [AW-1:0]     retire_pc,
    input  logic              store_valid,
    input  logic [AW-1:0]     store_addr,
    output logic              hit,
    output logic [REG_DW-1:0] ctrl_rd,
    output logic [AW-1:0]     match_rd
);
    logic          en_store_q;
    logic          en_exec_q;
    logic          prev_ie_q;
    logic [AW-1:0] match_q;
    logic          exec_hit;
    logic          store_hit;

    // Enable bits follow control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_store_q <= 1'b0;
            en_exec_q  <= 1'b0;
        end else if (ctrl_we) begin
            en_store_q <= ctrl_wbits[CB_STORE];
            en_exec_q  <= ctrl_wbits[CB_EXEC];
        end
    end

    // Saved-enable bit: a firing of this slot wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ie_q <= 1'b0;
        end else if (fired_here) begin
            prev_ie_q <= ie_now;
        end else if (ctrl_we) begin
            prev_ie_q <= ctrl_wbits[CB_PREV_IE];
        end
    end

    // Match address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (match_we) begin
            match_q <= match_wdata;
        end
    end

    // Exact compares, each gated by its own enable.
    always_comb begin
        exec_hit  = en_exec_q  && retire_valid && (retire_pc  == match_q);
        store_hit = en_store_q && store_valid  && (store_addr == match_q);
        hit       = exec_hit || store_hit;
    end

    // Control read view: the type field is fixed to address match.
    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[31:28]      = TYPE_ADDRESS;
        ctrl_rd[CB_STORE]   = en_store_q;
        ctrl_rd[CB_EXEC]    = en_exec_q;
        ctrl_rd[CB_PREV_IE] = prev_ie_q;
        match_rd            = match_q;
    end
endmodule

// File: rtl/dbgtrig_prio.sv
// Picks the lowest-index hit among N trigger hits.
// Assumes IW is wide enough to hold N-1.
module dbgtrig_prio #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dbgtrig_ie_ctl.sv
// Machine interrupt enable and its saved copy.
// Priority order: firing, then return, then software write.
module dbgtrig_ie_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ret,
    input  logic sw_we,
    input  logic sw_val,
    output logic ie,
    output logic ie_saved
);
    // Update the enable pair on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie       <= 1'b0;
            ie_saved <= 1'b0;
        end else if (fire) begin
            ie_saved <= ie;
            ie       <= 1'b0;
        end else if (ret) begin
            ie       <= ie_saved;
        end else if (sw_we) begin
            ie       <= sw_val;
        end
    end
endmodule

// File: rtl/addr_trigger_bank.sv
// Top of the trigger bank: select register, N trigger slots, the priority
// pick and the interrupt-enable hand-off. Assumes AW <= 32.
module addr_trigger_bank
    import dbgtrig_pkg::*;
#(
    parameter int N  = 2,
    parameter int AW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic [AW-1:0]     retire_pc,
    input  logic              store_valid,
    input  logic [AW-1:0]     store_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              trap_ret,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    output logic              trig_fire,
    output logic [IW-1:0]     trig_idx,
    output logic              ie,
    output logic              ie_saved
);
    logic [IW-1:0]     sel_q;
    logic [N-1:0]      hits;
    logic [REG_DW-1:0] ctrl_rd  [N];
    logic [AW-1:0]     match_rd [N];
    logic [REG_DW-1:0] ctrl_sel;
    logic [AW-1:0]     match_sel;
    cfg_reg_e          reg_id;

    assign reg_id = cfg_reg_e'(cfg_addr);

    // Select register: which slot the control and match accesses address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (cfg_we && reg_id == CFG_SELECT) begin
            sel_q <= cfg_wdata[IW-1:0];
        end
    end

    // One slot per trigger.
    for (genvar g = 0; g < N; g++) begin : g_slot
        dbgtrig_slot #(.AW(AW)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctrl_we      (cfg_we && reg_id == CFG_CTRL  && sel_q == IW'(g)),
            .ctrl_wbits   (cfg_wdata[2:0]),
            .match_we     (cfg_we && reg_id == CFG_MATCH && sel_q == IW'(g)),
            .match_wdata  (cfg_wdata[AW-1:0]),
            .fired_here   (trig_fire && trig_idx == IW'(g)),
            .ie_now       (ie),
            .retire_valid (retire_valid),
            .retire_pc    (retire_pc),
            .store_valid  (store_valid),
            .store_addr   (store_addr),
            .hit          (hits[g]),
            .ctrl_rd      (ctrl_rd[g]),
            .match_rd     (match_rd[g])
        );
    end

    dbgtrig_prio #(.N(N), .IW(IW)) u_prio (
        .hits (hits),
        .any  (trig_fire),
        .idx  (trig_idx)
    );

    dbgtrig_ie_ctl u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (trig_fire),
        .ret      (trap_ret),
        .sw_we    (ie_wr),
        .sw_val   (ie_wdata),
        .ie       (ie),
        .ie_saved (ie_saved)
    );

    // Pick the selected slot's registers for reading.
    always_comb begin
        ctrl_sel  = '0;
        match_sel = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_q == IW'(i)) begin
                ctrl_sel  = ctrl_rd[i];
                match_sel = match_rd[i];
            end
        end
    end

    // Read-data decode by register address.
    always_comb begin
        unique case (reg_id)
            CFG_SELECT: cfg_rdata = 32'(sel_q);
            CFG_CTRL:   cfg_rdata = ctrl_sel;
            CFG_MATCH:  cfg_rdata = 32'(match_sel);
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// Property checker bound to the trigger bank.
module addr_trigger_bank_chk #(
    parameter int N  = 2,
    parameter int AW = 32,
    parameter int IW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire_valid,
    input logic          store_valid,
    input logic [1:0]    cfg_addr,
    input logic [31:0]   cfg_rdata,
    input logic          trap_ret,
    input logic          trig_fire,
    input logic [IW-1:0] trig_idx,
    input logic          ie,
    input logic          ie_saved
);
    // R1
    type_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd1) |-> (cfg_rdata[31:28] == 4'h2));
    // R2
    fire_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |-> (retire_valid || store_valid));
    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |-> (int'(trig_idx) < N));
    // R6
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |=> !ie);
    // R6
    ie_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fire |=> (ie_saved == $past(ie)));
    // R7
    ie_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !trig_fire) |=> (ie == $past(ie_saved)));
    // R7
    saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_fire |=> $stable(ie_saved));
endmodule

bind addr_trigger_bank addr_trigger_bank_chk #(.N(N), .AW(AW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_valid (retire_valid),
    .store_valid  (store_valid),
    .cfg_addr     (cfg_addr),
    .cfg_rdata    (cfg_rdata),
    .trap_ret     (trap_ret),
    .trig_fire    (trig_fire),
    .trig_idx     (trig_idx),
    .ie           (ie),
    .ie_saved     (ie_saved)
);

// File: tb/addr_trigger_bank_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model of the trigger bank, compared every cycle.
module addr_trigger_bank_test;
    localparam int N = 2;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retire_valid = 1'b0, store_valid = 1'b0;
    logic [31:0] retire_pc = '0, store_addr = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic trap_ret = 1'b0, ie_wr = 1'b0, ie_wdata = 1'b0;
    logic trig_fire;
    logic [0:0] trig_idx;
    logic ie, ie_saved;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // model state
    int m_sel;
    bit m_se[N], m_xe[N], m_pie[N];
    logic [31:0] m_match[N];
    bit m_ie, m_sv;

    always #2 clk = ~clk;

    addr_trigger_bank #(.N(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(retire_valid), .retire_pc(retire_pc),
        .store_valid(store_valid), .store_addr(store_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .trap_ret(trap_ret),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .trig_fire(trig_fire), .trig_idx(trig_idx),
        .ie(ie), .ie_saved(ie_saved)
    );

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int model_hit();
        for (int i = 0; i < N; i++) begin
            if ((m_xe[i] && retire_valid && retire_pc == m_match[i]) ||
                (m_se[i] && store_valid && store_addr == m_match[i])) return i;
        end
        return -1;
    endfunction

    function automatic logic [31:0] model_rd();
        case (cfg_addr)
            2'd0: return 32'(m_sel);
            2'd1: return {4'h2, 25'd0, m_pie[m_sel], m_xe[m_sel], m_se[m_sel]};
            2'd2: return m_match[m_sel];
            default: return 32'd0;
        endcase
    endfunction

    // Apply inputs for one cycle, compare, then advance the model.
    task automatic step(string req, bit rv, logic [31:0] pc, bit sv, logic [31:0] sa,
                        bit we, logic [1:0] a, logic [31:0] wd,
                        bit rt, bit iw, bit iwd);
        int h;
        bit old_ie;
        retire_valid = rv; retire_pc = pc; store_valid = sv; store_addr = sa;
        cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        trap_ret = rt; ie_wr = iw; ie_wdata = iwd;
        #1;
        h = model_hit();
        cmp(req, "fire", 32'(trig_fire), 32'(h >= 0));
        if (h >= 0) cmp(req, "idx", 32'(trig_idx), 32'(h));
        cmp(req, "ie", 32'(ie), 32'(m_ie));
        cmp(req, "ie_saved", 32'(ie_saved), 32'(m_sv));
        cmp(req, "rdata", cfg_rdata, model_rd());
        @(posedge clk);
        old_ie = m_ie;
        if (we) begin
            if (a == 2'd1) begin
                m_se[m_sel] = wd[0]; m_xe[m_sel] = wd[1]; m_pie[m_sel] = wd[2];
            end else if (a == 2'd2) m_match[m_sel] = wd;
        end
        if (h >= 0) begin
            m_sv = old_ie; m_ie = 1'b0; m_pie[h] = old_ie;
        end else if (rt) m_ie = m_sv;
        else if (iw) m_ie = iwd;
        if (we && a == 2'd0) m_sel = int'(wd[0]);
        @(negedge clk);
    endtask

    task automatic wr(string req, logic [1:0] a, logic [31:0] wd);
        step(req, 0, 0, 0, 0, 1, a, wd, 0, 0, 0);
    endtask

    task automatic rd(string req, logic [1:0] a);
        step(req, 0, 0, 0, 0, 0, a, 0, 0, 0, 0);
    endtask

    initial begin
        m_sel = 0; m_ie = 0; m_sv = 0;
        for (int i = 0; i < N; i++) begin
            m_se[i] = 0; m_xe[i] = 0; m_pie[i] = 0; m_match[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, including a zero-address op that must not fire
        rd("R9", 2'd0); rd("R9", 2'd1); rd("R9", 2'd2);
        step("R9", 1, 0, 1, 0, 0, 2'd1, 0, 0, 0, 0);
        // R8: select trigger 1, program it, read back; address 3 reads 0
        wr("R8", 2'd0, 32'd1); rd("R8", 2'd0);
        wr("R8", 2'd2, 32'h0000_0200); rd("R8", 2'd2);
        // R1: type field written as 5 still reads 2; store enable on trigger 1
        wr("R1", 2'd1, 32'h5000_0001); rd("R1", 2'd1); rd("R8", 2'd3);
        // trigger 0: execute at 0x100
        wr("R8", 2'd0, 32'd0); wr("R8", 2'd2, 32'h0000_0100);
        wr("R8", 2'd1, 32'hF000_0002); rd("R1", 2'd1);
        // R10: software write of ie
        step("R10", 0, 0, 0, 0, 0, 2'd1, 0, 0, 1, 1);
        rd("R10", 2'd1);
        // R2: execute match on trigger 0, then R6 effects on ie and control bit 2
        step("R2", 1, 32'h100, 0, 0, 0, 2'd1, 0, 0, 0, 0);
        rd("R6", 2'd1);
        step("R2", 1, 32'h104, 0, 0, 0, 2'd1, 0, 0, 0, 0);
        // R7: return restores ie
        step("R7", 0, 0, 0, 0, 0, 2'd1, 0, 1, 0, 0);
        rd("R7", 2'd1);
        // R3: store match on trigger 1
        step("R3", 0, 0, 1, 32'h200, 0, 2'd1, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 32'h204, 0, 2'd1, 0, 0, 0, 0);
        // R10: write while firing is ignored (fire wins)
        step("R10", 0, 0, 1, 32'h200, 0, 2'd1, 0, 0, 1, 1);
        rd("R10", 2'd1);
        // R7: return and fire together: fire wins
        step("R7", 0, 0, 0, 0, 0, 2'd1, 0, 0, 1, 1);
        step("R7", 1, 32'h100, 0, 0, 0, 2'd1, 0, 1, 0, 0);
        rd("R7", 2'd1);
        // R4: wrong-kind matches do not fire
        step("R4", 0, 0, 1, 32'h100, 0, 2'd1, 0, 0, 0, 0);
        step("R4", 1, 32'h200, 0, 0, 0, 2'd1, 0, 0, 0, 0);
        // R4: trigger 0 with both enables clear never fires
        wr("R4", 2'd1, 32'h0);
        step("R4", 1, 32'h100, 1, 32'h100, 0, 2'd1, 0, 0, 0, 0);
        // R5: both triggers match at 0x300
        wr("R5", 2'd2, 32'h300); wr("R5", 2'd1, 32'h2);
        wr("R5", 2'd0, 32'd1); wr("R5", 2'd2, 32'h300); wr("R5", 2'd1, 32'h3);
        step("R5", 1, 32'h300, 1, 32'h300, 0, 2'd1, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 32'h300, 0, 2'd1, 0, 0, 0, 0);
        step("R5", 1, 32'h300, 0, 0, 0, 2'd1, 0, 0, 0, 0);
        wr("R8", 2'd0, 32'd0); rd("R6", 2'd1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule